// File: doc/BRIEF.md
# Parallel EEPROM Programming Sequencer

This block programs an 8-bit parallel EEPROM one byte at a time. A host hands it a command: either a single write (address plus data byte) or a clear pass. For each byte the sequencer shifts the target address serially, MSB first, into an external chain of shift registers and strobes a latch so the chain presents the address to the device. It then drives the data byte and pulses the active-low write enable while output enable stays inactive. After a settling gap it reads the device back again and again until the write has finished.

Completion is detected from the device's status behaviour rather than from a fixed worst-case delay. While the internal write runs, a read returns the complement of the written bit 7, and bit 6 toggles from one read to the next. The byte is done once the bit 7 read back equals the written bit 7. If that does not happen within a programmable number of reads, the command ends with an error flag. The clear pass writes the value 0x80 to every address in ascending order, one separate write cycle per byte, before any real content is programmed. Each command is acknowledged with a busy level and a single-cycle done pulse.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done, err, sr_clk and sr_latch are low, and ee_we_n and ee_oe_n are high.
- R2: A command is accepted on a cycle where cmd_valid is high and busy is low. busy is high from the next cycle until completion. cmd_valid is ignored while busy, so such a request writes nothing.
- R3: The address is sent MSB first on sr_data. Each bit gets exactly one rising edge of sr_clk, and sr_data is stable across that edge. After the ADDR_W-th bit, sr_latch pulses high while sr_clk is low, and the latched value is the commanded address.
- R4: For each byte, ee_dq_oe is high and ee_dq_out carries the data while ee_we_n is low. ee_we_n stays low for exactly WE_CYC cycles, and ee_we_n and ee_oe_n are never low together.
- R5: The first read after a write begins (ee_oe_n falls) no sooner than GAP_CYC cycles after ee_we_n returns high.
- R6: Reads hold ee_oe_n low for RD_CYC cycles with at least one high cycle between reads. Polling stops at the first read whose bit 7 equals written bit 7. Only bit 7 is judged, so a toggling bit 6 has no effect. A device busy for B reads costs exactly B+1 reads when B < MAX_POLLS.
- R7: If MAX_POLLS consecutive reads all return a mismatching bit 7, the command ends with done and err set. err then stays high until the next command is accepted, and is cleared by that acceptance.
- R8: done is high for exactly one cycle per command, in the cycle busy first reads low.
- R9: A command with cmd_erase high writes CLEAR_VAL (0x80) to every address from 0 up to 2^ADDR_W-1 in ascending order. It ignores cmd_addr and cmd_data and gives one done at the end.
- R10: Every byte is its own write cycle: a clear pass produces exactly 2^ADDR_W write-enable pulses and 2^ADDR_W latch strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_erase | input | 1 | 1: clear pass over the whole array, 0: single byte write |
| cmd_addr | input | ADDR_W | Byte address for a single write |
| cmd_data | input | 8 | Byte value for a single write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command ended on poll timeout |
| sr_data | output | 1 | Serial address bit to the shift chain |
| sr_clk | output | 1 | Shift clock to the chain |
| sr_latch | output | 1 | Strobe that moves the shifted address to the device |
| ee_we_n | output | 1 | Device write enable, active low |
| ee_oe_n | output | 1 | Device output enable, active low |
| ee_dq_oe | output | 1 | Drive enable for the data bus pads |
| ee_dq_out | output | 8 | Data driven toward the device |
| ee_dq_in | input | 8 | Data read from the device |

## Verification
The bench builds the block with ADDR_W=8, HALF_CYC=1, WE_CYC=2, GAP_CYC=2, RD_CYC=2 and MAX_POLLS=8. The narrow address makes a complete clear pass over all 256 locations short, so ascending order, per-byte write pulses and the final contents of every location can all be checked. The small poll limit puts both sides of the timeout edge within reach: a device busy for 7 reads still succeeds, and one busy for 8 reads fails. The device model toggles bit 6 and complements bit 7 while busy, so writes with bit 7 set and clear both exercise the polling.

// File: rtl/eeprog_pkg.sv
// Shared types for the EEPROM programming sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package eeprog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_WRITE,
        ST_GAP,
        ST_READ,
        ST_CHECK
    } ctl_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/eeprog_addr_shifter.sv
// Serialises an address MSB first onto a data/clock pair, then strobes a latch.
// Assumes: start is a one-cycle pulse given only while idle; addr is valid
// in the start cycle. Each clock half and the latch last HALF_CYC cycles.
module eeprog_addr_shifter #(
    parameter int ADDR_W   = 12,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              sr_data,
    output logic              sr_clk,
    output logic              sr_latch,
    output logic              fin
);
    localparam int IDX_W = $clog2(ADDR_W);
    localparam int HC_W  = $clog2(HALF_CYC + 1);

    logic [ADDR_W-1:0] sreg;
    logic [IDX_W-1:0]  idx;
    logic [HC_W-1:0]   hcnt;
    logic              shifting, clk_hi, latching, fin_q;

    // Walk bits with clock halves, then hold the latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            idx      <= '0;
            hcnt     <= '0;
            shifting <= 1'b0;
            clk_hi   <= 1'b0;
            latching <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                sreg     <= addr;
                idx      <= IDX_W'(ADDR_W - 1);
                hcnt     <= HC_W'(HALF_CYC - 1);
                shifting <= 1'b1;
                clk_hi   <= 1'b0;
                latching <= 1'b0;
            end else if (shifting) begin
                if (hcnt != '0) begin
                    hcnt <= hcnt - HC_W'(1);
                end else begin
                    hcnt <= HC_W'(HALF_CYC - 1);
                    if (!clk_hi) begin
                        clk_hi <= 1'b1;
                    end else begin
                        clk_hi <= 1'b0;
                        if (idx == '0) begin
                            shifting <= 1'b0;
                            latching <= 1'b1;
                        end else begin
                            idx  <= idx - IDX_W'(1);
                            sreg <= sreg << 1;
                        end
                    end
                end
            end else if (latching) begin
                if (hcnt != '0) begin
                    hcnt <= hcnt - HC_W'(1);
                end else begin
                    latching <= 1'b0;
                    fin_q    <= 1'b1;
                end
            end
        end
    end

    assign sr_data  = sreg[ADDR_W-1];
    assign sr_clk   = clk_hi;
    assign sr_latch = latching;
    assign fin      = fin_q;

endmodule

// File: rtl/eeprog_phase_timer.sv
// Down counter that times a bus phase: after load with len, expired rises len cycles later.
// Assumes: len >= 1.
module eeprog_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= len - CNT_W'(1);
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/eeprog_poll_counter.sv
// Counts status reads for one byte and flags when the limit is reached.
// Assumes: clr and inc never coincide; MAX_POLLS >= 1.
module eeprog_poll_counter #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt;

    // Saturating read counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt <= '0;
        else if (clr)                               cnt <= '0;
        else if (inc && cnt != PW'(MAX_POLLS))      cnt <= cnt + PW'(1);
    end

    assign at_limit = (cnt == PW'(MAX_POLLS));

endmodule

// File: rtl/eeprom_prog_ctrl.sv
// EEPROM programming sequencer: shift address, pulse write, poll bit 7 until
// the device reports completion, with timeout and an optional clear pass.
// Assumes: the device complements written bit 7 while busy; the external
// shift chain samples sr_data on sr_clk rising and updates on sr_latch rising.
module eeprom_prog_ctrl #(
    parameter int         ADDR_W    = 12,
    parameter int         HALF_CYC  = 2,
    parameter int         WE_CYC    = 4,
    parameter int         GAP_CYC   = 3,
    parameter int         RD_CYC    = 2,
    parameter int         MAX_POLLS = 1000,
    parameter logic [7:0] CLEAR_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              sr_data,
    output logic              sr_clk,
    output logic              sr_latch,
    output logic              ee_we_n,
    output logic              ee_oe_n,
    output logic              ee_dq_oe,
    output logic [7:0]        ee_dq_out,
    input  logic [7:0]        ee_dq_in
);
    import eeprog_pkg::*;

    localparam int PH_MAX = max3(WE_CYC, GAP_CYC, RD_CYC);
    localparam int PH_W   = $clog2(PH_MAX + 1);

    ctl_state_e        state, state_n;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              erase_q, rd_b7, shift_go, busy_q, done_q, err_q;
    logic              sh_fin, tmr_load, tmr_exp, poll_clr, poll_inc, poll_lim;
    logic [PH_W-1:0]   tmr_len;
    logic              accept, step_next, finish, timeout;

    eeprog_addr_shifter #(.ADDR_W(ADDR_W), .HALF_CYC(HALF_CYC)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(shift_go), .addr(addr_q),
        .sr_data(sr_data), .sr_clk(sr_clk), .sr_latch(sr_latch), .fin(sh_fin)
    );

    eeprog_phase_timer #(.CNT_W(PH_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
    );

    eeprog_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .at_limit(poll_lim)
    );

    // Next-state and phase control decisions.
    always_comb begin
        state_n   = state;
        tmr_load  = 1'b0;
        tmr_len   = PH_W'(WE_CYC);
        poll_clr  = 1'b0;
        poll_inc  = 1'b0;
        accept    = 1'b0;
        step_next = 1'b0;
        finish    = 1'b0;
        timeout   = 1'b0;
        unique case (state)
            ST_IDLE: if (cmd_valid) begin
                accept  = 1'b1;
                state_n = ST_SHIFT;
            end
            ST_SHIFT: if (sh_fin) begin
                tmr_load = 1'b1;
                tmr_len  = PH_W'(WE_CYC);
                poll_clr = 1'b1;
                state_n  = ST_WRITE;
            end
            ST_WRITE: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_len  = PH_W'(GAP_CYC);
                state_n  = ST_GAP;
            end
            ST_GAP: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_len  = PH_W'(RD_CYC);
                state_n  = ST_READ;
            end
            ST_READ: if (tmr_exp) begin
                poll_inc = 1'b1;
                state_n  = ST_CHECK;
            end
            ST_CHECK: begin
                if (rd_b7 == data_q[7]) begin
                    if (erase_q && addr_q != '1) begin
                        step_next = 1'b1;
                        state_n   = ST_SHIFT;
                    end else begin
                        finish  = 1'b1;
                        state_n = ST_IDLE;
                    end
                end else if (poll_lim) begin
                    timeout = 1'b1;
                    finish  = 1'b1;
                    state_n = ST_IDLE;
                end else begin
                    tmr_load = 1'b1;
                    tmr_len  = PH_W'(RD_CYC);
                    state_n  = ST_READ;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Command capture, address stepping, status and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            data_q   <= '0;
            erase_q  <= 1'b0;
            rd_b7    <= 1'b0;
            shift_go <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state    <= state_n;
            shift_go <= accept | step_next;
            done_q   <= finish;
            if (accept) begin
                busy_q  <= 1'b1;
                err_q   <= 1'b0;
                erase_q <= cmd_erase;
                addr_q  <= cmd_erase ? '0 : cmd_addr;
                data_q  <= cmd_erase ? CLEAR_VAL : cmd_data;
            end
            if (step_next) addr_q <= addr_q + ADDR_W'(1);
            if (finish)    busy_q <= 1'b0;
            if (timeout)   err_q  <= 1'b1;
            if (state == ST_READ && tmr_exp) rd_b7 <= ee_dq_in[7];
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign err       = err_q;
    assign ee_we_n   = (state != ST_WRITE);
    assign ee_oe_n   = (state != ST_READ);
    assign ee_dq_oe  = (state == ST_WRITE) || (state == ST_GAP);
    assign ee_dq_out = data_q;

endmodule

// File: rtl/eeprog_ctrl_checker.sv
// Protocol checks on the sequencer's pins, bound into every instance.
// Assumes: the same GAP_CYC value as the checked instance.
module eeprog_ctrl_checker #(
    parameter int GAP_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic sr_clk,
    input logic sr_latch,
    input logic ee_we_n,
    input logic ee_oe_n,
    input logic ee_dq_oe
);
    localparam int SW = $clog2(GAP_CYC + 1) + 1;

    logic [SW-1:0] since_we;

    // Cycles spent with write enable high, saturating at the gap length.
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_we <= SW'(GAP_CYC);
        else if (!ee_we_n)                   since_we <= '0;
        else if (since_we != SW'(GAP_CYC))   since_we <= since_we + SW'(1);
    end

    AST_WE_OE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(!ee_we_n && !ee_oe_n)); // R4
    AST_WE_DRIVES:    assert property (@(posedge clk) disable iff (!rst_n) !ee_we_n |-> ee_dq_oe); // R4
    AST_LATCH_LOWCLK: assert property (@(posedge clk) disable iff (!rst_n) sr_latch |-> !sr_clk); // R3
    AST_READ_GAP:     assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_oe_n) |-> since_we == SW'(GAP_CYC)); // R5
    AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
    AST_DONE_AFTER:   assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R2
    AST_ERR_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (err && !busy && !cmd_valid) |=> err); // R7

endmodule

bind eeprom_prog_ctrl eeprog_ctrl_checker #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
    .err(err), .sr_clk(sr_clk), .sr_latch(sr_latch), .ee_we_n(ee_we_n),
    .ee_oe_n(ee_oe_n), .ee_dq_oe(ee_dq_oe)
);

// File: tb/tb_eeprom_prog_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_prog_ctrl;
    localparam int ADDR_W = 8;
    localparam int NLOC   = 1 << ADDR_W;
    localparam int WE_C   = 2;
    localparam int GAP_C  = 2;
    localparam int MAXP   = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, cmd_valid, cmd_erase;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    logic              busy, done, err, sr_data, sr_clk, sr_latch;
    logic              ee_we_n, ee_oe_n, ee_dq_oe;
    logic [7:0]        ee_dq_out, ee_dq_in;

    eeprom_prog_ctrl #(.ADDR_W(ADDR_W), .HALF_CYC(1), .WE_CYC(WE_C), .GAP_CYC(GAP_C),
                       .RD_CYC(2), .MAX_POLLS(MAXP), .CLEAR_VAL(8'h80)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done), .err(err),
        .sr_data(sr_data), .sr_clk(sr_clk), .sr_latch(sr_latch), .ee_we_n(ee_we_n),
        .ee_oe_n(ee_oe_n), .ee_dq_oe(ee_dq_oe), .ee_dq_out(ee_dq_out), .ee_dq_in(ee_dq_in)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- device and shift-chain model ----------------
    logic [7:0]        mem [0:NLOC-1];
    logic [ADDR_W-1:0] sh_reg = '0, lat_addr = '0, prev_lat = '0, pend_addr = '0;
    logic [7:0]        pend = '0;
    logic              tog = 1'b0, order_on = 1'b0;
    int busy_cfg = 0, busy_left = 0, reads = 0, writes = 0, latches = 0;
    int clk_rises = 0, clk_bad = 0, order_bad = 0;

    always @(posedge sr_clk) begin
        sh_reg    = {sh_reg[ADDR_W-2:0], sr_data};
        clk_rises = clk_rises + 1;
    end

    always @(posedge sr_latch) begin
        if (clk_rises != ADDR_W) clk_bad++;
        clk_rises = 0;
        latches++;
        if (order_on && sh_reg != ADDR_W'(prev_lat + 1)) order_bad++;
        prev_lat = sh_reg;
        lat_addr = sh_reg;
    end

    always @(posedge ee_we_n) if (rst_n) begin
        writes++;
        pend      = ee_dq_out;
        pend_addr = lat_addr;
        busy_left = busy_cfg;
        tog       = 1'b0;
        if (busy_left == 0) mem[pend_addr] = pend;
    end

    always @(posedge ee_oe_n) if (rst_n) begin
        reads++;
        if (busy_left > 0) begin
            busy_left = busy_left - 1;
            tog = ~tog;
            if (busy_left == 0) mem[pend_addr] = pend;
        end
    end

    assign ee_dq_in = (busy_left > 0) ? {~pend[7], tog, pend[5:0]} : mem[lat_addr];

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         erase;
        bit         err;
        logic [7:0] addr;
        logic [7:0] data;
        int         nreads;
        int         rd_base;
        int         wr_base;
    } exp_t;
    exp_t q[$];

    int we_run = 0, we_bad = 0, overlap = 0, since_we = 0, gap_bad = 0, done_bad = 0;
    bit after_we = 1'b0, prev_oe = 1'b1, prev_done = 1'b0;

    // Monitor: pin timing bookkeeping and comparison at each done.
    always @(negedge clk) if (rst_n) begin
        if (!ee_we_n && !ee_oe_n) overlap++;
        if (!ee_we_n) begin
            we_run++; since_we = 0; after_we = 1'b1;
        end else begin
            if (we_run != 0 && we_run != WE_C) we_bad++;
            we_run = 0;
        end
        if (prev_oe && !ee_oe_n && after_we) begin
            if (since_we < GAP_C) gap_bad++;
            after_we = 1'b0;
        end
        if (ee_we_n) since_we++;
        prev_oe = ee_oe_n;
        if (done && prev_done) done_bad++;
        if (done && busy) done_bad++;
        prev_done = done;
        if (done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(err == e.err, "R7 err at done", int'(err), int'(e.err));
                chk(reads - e.rd_base == e.nreads, "R6 read count", reads - e.rd_base, e.nreads);
                if (e.erase) begin
                    int bad;
                    bad = 0;
                    for (int i = 0; i < NLOC; i++) if (mem[i] != 8'h80) bad++;
                    chk(bad == 0, "R9 locations not cleared", bad, 0);
                    chk(writes - e.wr_base == NLOC, "R10 write pulses", writes - e.wr_base, NLOC);
                end else if (!e.err) begin
                    chk(mem[e.addr] == e.data, "R3 byte at address", int'(mem[e.addr]), int'(e.data));
                end
            end
        end
    end

    // Driver: push expectation, then present the command for one cycle.
    task automatic start_cmd(input bit erase, input logic [7:0] a, input logic [7:0] d,
                             input int bsy, input bit exp_err, input int exp_reads);
        exp_t e;
        e.erase = erase; e.err = exp_err; e.addr = a; e.data = d;
        e.nreads = exp_reads; e.rd_base = reads; e.wr_base = writes;
        busy_cfg = bsy;
        q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_erase = erase; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_erase = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmd(input bit erase, input logic [7:0] a, input logic [7:0] d,
                           input int bsy, input bit exp_err, input int exp_reads);
        start_cmd(erase, a, d, bsy, exp_err, exp_reads);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_erase = 1'b0; cmd_addr = '0; cmd_data = '0;
        for (int i = 0; i < NLOC; i++) mem[i] = 8'(i * 7 + 3);
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err, "R1 status low in reset", {busy, done, err}, 0);
        chk(ee_we_n && ee_oe_n, "R1 strobes idle in reset", {ee_we_n, ee_oe_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !sr_clk && !sr_latch, "R1 after reset",
            {busy, done, err, sr_clk, sr_latch}, 0);

        // R9/R10: clear pass, device busy for one read per byte
        order_on = 1'b1; prev_lat = '1;
        run_cmd(1'b1, 8'h33, 8'h11, 1, 1'b0, 2 * NLOC);
        order_on = 1'b0;
        chk(order_bad == 0, "R9 ascending order", order_bad, 0);
        chk(clk_bad == 0, "R3 shift clocks per address", clk_bad, 0);

        // R6: bit 7 set, three busy reads
        run_cmd(1'b0, 8'h5A, 8'hA5, 3, 1'b0, 4);
        // R6: bit 7 clear, ready at once
        run_cmd(1'b0, 8'hC3, 8'h3C, 0, 1'b0, 1);

        // R2: request while busy is ignored
        start_cmd(1'b0, 8'h77, 8'h12, 5, 1'b0, 6);
        repeat (4) @(negedge clk);
        chk(busy, "R2 busy during command", int'(busy), 1);
        cmd_valid = 1'b1; cmd_addr = 8'h11; cmd_data = 8'h00;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        chk(mem[8'h11] == 8'h80, "R2 ignored request left byte", int'(mem[8'h11]), 8'h80);

        // R6: longest successful poll run
        run_cmd(1'b0, 8'h20, 8'h9E, MAXP - 1, 1'b0, MAXP);
        // R7: timeout exactly at the limit
        run_cmd(1'b0, 8'h21, 8'h44, MAXP, 1'b1, MAXP);
        repeat (10) @(negedge clk);
        chk(err, "R7 err held while idle", int'(err), 1);
        busy_cfg = 0;
        run_cmd(1'b0, 8'h22, 8'h81, 2, 1'b0, 3);
        chk(!err, "R7 err cleared by new command", int'(err), 0);

        chk(overlap == 0, "R4 WE and OE overlap", overlap, 0);
        chk(we_bad == 0, "R4 write pulse width", we_bad, 0);
        chk(gap_bad == 0, "R5 write-to-read gap", gap_bad, 0);
        chk(done_bad == 0, "R8 done shape", done_bad, 0);
        chk(latches == writes, "R10 one latch per write", latches, writes);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule